// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a processor's instruction fetch port and a plain request/response memory bus. Each fetch address is looked up in a direct-mapped array of lines. A hit answers in the same cycle. A miss stalls the processor, sends one burst read that covers the whole line, stores the returned words and then serves the fetch from the refreshed line.

A parameterised set of address windows marks parts of the address space as uncached. A fetch that falls in any window never looks at the array. It stalls while a single-word read goes out, and it is answered from that one returned word without allocating a line. The block only reads: its bus has no write path at all.

The fetch side holds `fetch_req` and `fetch_addr` steady until it sees `fetch_valid`. It then either drops the request or moves to a new address on the next clock. The bus side accepts a request when `mem_req_valid` and `mem_req_ready` are both high. It returns the words of that request in address order, one for each cycle in which `mem_rsp_valid` is high.

Top module: `ifetch_cache`

## Requirements
- R1: After reset every line is invalid, `mem_req_valid` and `fetch_valid` are low, and the first fetch of any cached address causes a line read.
- R2: A fetch to a cached address whose line is valid and whose tag matches raises `fetch_valid` with the stored word in the same cycle, keeps `fetch_stall` low and sends no bus request.
- R3: A cached miss sends exactly one request, with `mem_req_len` equal to 4 and `mem_req_addr` equal to the fetch address with bits [3:0] cleared.
- R4: Refill words are stored at word offsets 0, 1, 2, 3 in arrival order. The line turns valid only with the last word, and the stalled fetch is answered in the cycle after that word arrives.
- R5: While a fetch is outstanding and not yet answered, `fetch_stall` is high and `fetch_valid` is low. When the fetch is answered, `fetch_stall` is low.
- R6: A fetch whose address matches an uncached window (bits [31:28] equal to 0xF, or bits [31:16] equal to 0x0001) sends one request with length 1 at the word-aligned address. It is answered in the cycle after the response word. No line is allocated, so repeating the fetch sends another request.
- R7: Addresses that share index bits [7:4] but differ in tag bits [31:8] evict one another, and each return to the other address misses again.
- R8: A request that is not accepted stays asserted, with the same address and length, until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Processor fetch request, held until answered |
| fetch_addr | input | 32 | Byte address of the fetch |
| fetch_valid | output | 1 | Instruction word on `fetch_data` is valid this cycle |
| fetch_stall | output | 1 | Fetch is pending and the processor must wait |
| fetch_data | output | 32 | Instruction word |
| mem_req_valid | output | 1 | Read request to memory is valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the first word read |
| mem_req_len | output | 3 | Number of words requested (4 or 1) |
| mem_rsp_valid | input | 1 | Response word is valid |
| mem_rsp_data | input | 32 | Response word |

## Verification
With a bus that is always ready and never pauses, a hit is due at the first sample after the fetch is presented. A line miss is due six cycles later: one cycle to decide, one to hand over the request, four response words. An uncached fetch is due three cycles later. The bench counts cycles from the fetch and compares them with these figures in the fast phase. In the phase with a stalling bus it checks each answer against a scoreboard of expected words and bus requests in issue order. All sampling happens on the falling edge, so both the combinational hit path and the registered refill results are seen settled.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_COLLECT,
    ST_BYPASS_OUT
  } ifc_state_e;
endpackage

// File: rtl/ifc_uc_decode.sv
module ifc_uc_decode #(
  parameter int AW = 32,
  parameter int N_WIN = 2,
  parameter logic [N_WIN*AW-1:0] WIN_BASE = '0,
  parameter logic [N_WIN*AW-1:0] WIN_MASK = '0
) (
  input  logic [AW-1:0] addr,
  output logic          uncached
);
  logic [N_WIN-1:0] win_hit;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    assign win_hit[w] = ((addr & WIN_MASK[w*AW +: AW]) == WIN_BASE[w*AW +: AW]);
  end

  assign uncached = |win_hit;
endmodule

// File: rtl/ifc_line_store.sv
module ifc_line_store #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [$clog2(NUM_LINES)-1:0]              rd_index,
  input  logic [AW-$clog2(NUM_LINES)-$clog2(LINE_WORDS)-3:0] rd_tag,
  input  logic [$clog2(LINE_WORDS)-1:0]             rd_off,
  output logic                                      rd_hit,
  output logic [DW-1:0]                             rd_data,
  input  logic                                      fill_we,
  input  logic                                      fill_last,
  input  logic [$clog2(NUM_LINES)-1:0]              fill_index,
  input  logic [AW-$clog2(NUM_LINES)-$clog2(LINE_WORDS)-3:0] fill_tag,
  input  logic [$clog2(LINE_WORDS)-1:0]             fill_off,
  input  logic [DW-1:0]                             fill_data
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int TAG_W = AW - IDX_W - OFF_W - 2;

  logic [NUM_LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [DW-1:0]        data_q [NUM_LINES][LINE_WORDS];

  // A line is cleared by its first refill word and set by its last one.
  always_comb begin
    valid_d = valid_q;
    if (fill_we) valid_d[fill_index] = fill_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_q[fill_index]            <= fill_tag;
      data_q[fill_index][fill_off] <= fill_data;
    end
  end

  assign rd_hit  = valid_q[rd_index] && (tag_q[rd_index] == rd_tag);
  assign rd_data = data_q[rd_index][rd_off];

  // R4: the line becomes usable only with its last refill word
  a_r4_valid_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we && fill_last |=> valid_q[$past(fill_index)]);
  a_r4_invalid_mid_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we && !fill_last |=> !valid_q[$past(fill_index)]);
endmodule

// File: rtl/ifc_fsm.sv
module ifc_fsm
  import ifc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fetch_req,
  input  logic [AW-1:0]                 fetch_addr,
  input  logic                          uncached,
  input  logic                          hit,
  output logic                          idle,
  output logic                          bypass_out,
  output logic [DW-1:0]                 bypass_data,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [AW-1:0]                 mem_req_addr,
  output logic [$clog2(LINE_WORDS):0]   mem_req_len,
  input  logic                          mem_rsp_valid,
  input  logic [DW-1:0]                 mem_rsp_data,
  output logic                          fill_we,
  output logic                          fill_last,
  output logic [$clog2(LINE_WORDS)-1:0] fill_off
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int LEN_W = OFF_W + 1;
  localparam int LOW_W = OFF_W + 2;

  ifc_state_e        state_q, state_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              byp_q, byp_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]     ucd_q;
  logic              launch, cnt_last, ucd_en;

  assign launch   = (state_q == ST_IDLE) && fetch_req && (uncached || !hit);
  assign cnt_last = (cnt_q == OFF_W'(LINE_WORDS - 1));
  assign ucd_en   = (state_q == ST_COLLECT) && mem_rsp_valid && byp_q;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    len_d   = len_q;
    byp_d   = byp_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = ST_ISSUE;
          byp_d   = uncached;
          cnt_d   = '0;
          if (uncached) begin
            addr_d = {fetch_addr[AW-1:2], 2'b00};
            len_d  = LEN_W'(1);
          end else begin
            addr_d = {fetch_addr[AW-1:LOW_W], {LOW_W{1'b0}}};
            len_d  = LEN_W'(LINE_WORDS);
          end
        end
      end
      ST_ISSUE: begin
        if (mem_req_ready) state_d = ST_COLLECT;
      end
      ST_COLLECT: begin
        if (mem_rsp_valid) begin
          if (byp_q) begin
            state_d = ST_BYPASS_OUT;
          end else begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_last) state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      byp_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      len_q   <= len_d;
      byp_q   <= byp_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ucd_en) ucd_q <= mem_rsp_data;
  end

  assign idle          = (state_q == ST_IDLE);
  assign bypass_out    = (state_q == ST_BYPASS_OUT);
  assign bypass_data   = ucd_q;
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = addr_q;
  assign mem_req_len   = len_q;
  assign fill_we       = (state_q == ST_COLLECT) && mem_rsp_valid && !byp_q;
  assign fill_last     = cnt_last;
  assign fill_off      = cnt_q;

  // R8: a pending request keeps its address and length
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len));
  // R3 and R6: only the two legal lengths appear on the bus
  a_r3_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_len == LEN_W'(LINE_WORDS)) || (mem_req_len == LEN_W'(1)));
  // R3: line reads start on a line boundary
  a_r3_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && (mem_req_len == LEN_W'(LINE_WORDS)) |-> (mem_req_addr[LOW_W-1:0] == '0));
  // R6: a bypass answer comes only after a response word
  a_r6_bypass_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_out) |-> $past(mem_rsp_valid));
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES = 16,
  parameter int N_UC_WIN = 2,
  parameter logic [N_UC_WIN*AW-1:0] UC_BASE = {32'h0001_0000, 32'hF000_0000},
  parameter logic [N_UC_WIN*AW-1:0] UC_MASK = {32'hFFFF_0000, 32'hF000_0000}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fetch_req,
  input  logic [AW-1:0]               fetch_addr,
  output logic                        fetch_valid,
  output logic                        fetch_stall,
  output logic [DW-1:0]               fetch_data,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [AW-1:0]               mem_req_addr,
  output logic [$clog2(LINE_WORDS):0] mem_req_len,
  input  logic                        mem_rsp_valid,
  input  logic [DW-1:0]               mem_rsp_data
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int TAG_W = AW - IDX_W - OFF_W - 2;
  localparam int IDX_LO = OFF_W + 2;
  localparam int TAG_LO = IDX_LO + IDX_W;

  logic             uncached, hit, idle, bypass_out;
  logic [DW-1:0]    bypass_data, rd_data;
  logic             fill_we, fill_last;
  logic [OFF_W-1:0] fill_off;
  logic             hit_ok;

  ifc_uc_decode #(
    .AW(AW), .N_WIN(N_UC_WIN), .WIN_BASE(UC_BASE), .WIN_MASK(UC_MASK)
  ) i_decode (
    .addr(fetch_addr), .uncached(uncached)
  );

  ifc_line_store #(
    .AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
  ) i_store (
    .clk(clk), .rst_n(rst_n),
    .rd_index(fetch_addr[TAG_LO-1:IDX_LO]),
    .rd_tag(fetch_addr[AW-1:TAG_LO]),
    .rd_off(fetch_addr[IDX_LO-1:2]),
    .rd_hit(hit), .rd_data(rd_data),
    .fill_we(fill_we), .fill_last(fill_last),
    .fill_index(mem_req_addr[TAG_LO-1:IDX_LO]),
    .fill_tag(mem_req_addr[AW-1:TAG_LO]),
    .fill_off(fill_off), .fill_data(mem_rsp_data)
  );

  ifc_fsm #(
    .AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .uncached(uncached), .hit(hit),
    .idle(idle), .bypass_out(bypass_out), .bypass_data(bypass_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fill_we(fill_we), .fill_last(fill_last), .fill_off(fill_off)
  );

  assign hit_ok      = idle && !uncached && hit;
  assign fetch_valid = fetch_req && (hit_ok || bypass_out);
  assign fetch_stall = fetch_req && !fetch_valid;
  assign fetch_data  = bypass_out ? bypass_data : rd_data;

  // R2: an answer from the array never coincides with bus traffic
  a_r2_hit_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !bypass_out |-> !mem_req_valid);
  // R5: stall and valid never overlap
  a_r5_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && fetch_stall));
endmodule

// File: tb/test_ifetch_cache.sv
module test_ifetch_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        fetch_valid, fetch_stall;
  logic [31:0] fetch_data;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic [2:0]  mem_req_len;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int n_checks = 0;
  int n_errors = 0;
  bit slow_mode = 0;
  bit done = 0;

  logic [31:0] exp_data_q[$];
  string       exp_tag_q[$];
  logic [31:0] exp_baddr_q[$];
  int          exp_blen_q[$];
  string       exp_btag_q[$];

  ifetch_cache i_ifetch_cache (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .fetch_stall(fetch_stall), .fetch_data(fetch_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model: optional back-pressure and response gaps in slow mode
  logic [31:0] pend_addr;
  int          pend_left;
  logic [7:0]  lfsr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr     <= '0;
      pend_left     <= 0;
      lfsr          <= 8'hA7;
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      automatic logic [31:0] a = pend_addr;
      automatic int          l = pend_left;
      automatic logic [7:0]  nl = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (mem_rsp_valid) begin
        a = a + 32'd4;
        l = l - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        a = mem_req_addr;
        l = int'(mem_req_len);
      end
      lfsr          <= nl;
      mem_req_ready <= slow_mode ? nl[0] : 1'b1;
      mem_rsp_valid <= (l != 0) && (slow_mode ? nl[2] : 1'b1);
      mem_rsp_data  <= mem_word(a);
      pend_addr     <= a;
      pend_left     <= l;
    end
  end

  // Monitor: fetch answers, stall, bus requests and request holding
  bit          prev_wait = 0;
  logic [31:0] prev_addr;
  logic [2:0]  prev_len;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (fetch_req && fetch_valid) begin
        check(!fetch_stall, "R5", "stall with answer", {31'b0, fetch_stall}, 32'h0);
        if (exp_data_q.size() == 0) begin
          check(1'b0, "R2", "unexpected answer", fetch_data, 32'h0);
        end else begin
          automatic logic [31:0] e = exp_data_q.pop_front();
          automatic string t = exp_tag_q.pop_front();
          check(fetch_data == e, t, "fetch data", fetch_data, e);
        end
      end else if (fetch_req) begin
        check(fetch_stall, "R5", "stall while pending", {31'b0, fetch_stall}, 32'h1);
      end
      if (prev_wait) begin
        check(mem_req_valid && mem_req_addr == prev_addr && mem_req_len == prev_len,
              "R8", "held request", mem_req_addr, prev_addr);
      end
      prev_wait = mem_req_valid && !mem_req_ready;
      prev_addr = mem_req_addr;
      prev_len  = mem_req_len;
      if (mem_req_valid && mem_req_ready) begin
        if (exp_baddr_q.size() == 0) begin
          check(1'b0, "R2", "unexpected bus request", mem_req_addr, 32'h0);
        end else begin
          automatic logic [31:0] ea = exp_baddr_q.pop_front();
          automatic int el = exp_blen_q.pop_front();
          automatic string bt = exp_btag_q.pop_front();
          check(mem_req_addr == ea, bt, "request address", mem_req_addr, ea);
          check(int'(mem_req_len) == el, bt, "request length", {29'b0, mem_req_len}, el);
        end
      end
    end
  end

  // Driver: kind 0 = hit, 1 = line read, 2 = single-word read; lat < 0 skips timing
  task automatic do_fetch(input logic [31:0] a, input int kind, input int lat, input string req);
    int waited = 0;
    fetch_req  = 1'b1;
    fetch_addr = a;
    exp_data_q.push_back(mem_word({a[31:2], 2'b00}));
    exp_tag_q.push_back(req);
    if (kind == 1) begin
      exp_baddr_q.push_back({a[31:4], 4'h0});
      exp_blen_q.push_back(4);
      exp_btag_q.push_back(req);
    end else if (kind == 2) begin
      exp_baddr_q.push_back({a[31:2], 2'b00});
      exp_blen_q.push_back(1);
      exp_btag_q.push_back(req);
    end
    @(negedge clk);
    while (!fetch_valid && waited < 2000) begin
      waited++;
      @(negedge clk);
    end
    if (lat >= 0) check(waited == lat, req, "answer latency", waited, lat);
    @(posedge clk);
    #1;
    fetch_req = 1'b0;
  endtask

  initial begin
    rst_n      = 1'b0;
    fetch_req  = 1'b0;
    fetch_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check(!mem_req_valid, "R1", "req valid after reset", {31'b0, mem_req_valid}, 32'h0);
    check(!fetch_valid, "R1", "fetch valid after reset", {31'b0, fetch_valid}, 32'h0);
    check(!fetch_stall, "R1", "stall after reset", {31'b0, fetch_stall}, 32'h0);
    @(posedge clk);
    #1;

    // R1 R3 R4: first fetch misses, word at offset 2, answered 6 cycles later
    do_fetch(32'h0000_0048, 1, 6, "R1");
    // R2 R4: other offsets of the line hit with no bus traffic
    do_fetch(32'h0000_0040, 0, 0, "R4");
    do_fetch(32'h0000_0044, 0, 0, "R4");
    do_fetch(32'h0000_004C, 0, 0, "R2");
    do_fetch(32'h0000_0048, 0, 0, "R2");
    // R7: same index, different tag
    do_fetch(32'h0000_1044, 1, 6, "R7");
    do_fetch(32'h0000_1040, 0, 0, "R7");
    do_fetch(32'h0000_0048, 1, 6, "R7");
    // R3: another line, misaligned in-line start
    do_fetch(32'h0000_0A3C, 1, 6, "R3");
    do_fetch(32'h0000_0A30, 0, 0, "R3");
    // R6: uncached windows, no allocation
    do_fetch(32'hF000_0104, 2, 3, "R6");
    do_fetch(32'hF000_0104, 2, 3, "R6");
    do_fetch(32'h0001_0048, 2, 3, "R6");
    do_fetch(32'h0000_0048, 0, 0, "R6");

    // R5 R8: stalling bus
    slow_mode = 1;
    do_fetch(32'h0000_0204, 1, -1, "R5");
    do_fetch(32'h0000_0200, 0, 0, "R5");
    do_fetch(32'h0000_020C, 0, 0, "R4");
    do_fetch(32'hF123_4568, 2, -1, "R8");
    do_fetch(32'h0000_3208, 1, -1, "R8");
    do_fetch(32'h0001_FFFC, 2, -1, "R6");
    do_fetch(32'h0000_0208, 1, -1, "R7");
    slow_mode = 0;
    repeat (4) @(posedge clk);

    check(exp_data_q.size() == 0, "R2", "answers left", exp_data_q.size(), 0);
    check(exp_baddr_q.size() == 0, "R3", "requests left", exp_baddr_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "R5", "watchdog expired", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule